// File: doc/BRIEF.md
# Cross-Domain Indirect Register Bridge

This block gives software in a fast CPU clock domain access to a register file that runs on a slow, always-on clock. Software does not reach the remote registers directly. It stages a remote address, a mode/byte-enable word and, for writes, a data word in a small window of CPU-side registers. It then writes a start bit to the control register. The control register reads one while the transfer is in flight. Software polls it until it reads zero and then, for a read, fetches the result from the data register.

Internally, the start is captured together with a snapshot of the staged values in a holding register. A request toggle crosses to the remote domain through a two-flop synchronizer. The remote side issues exactly one single-cycle access on a simple register bus and flips an acknowledge toggle, which crosses back the same way. Read data is latched on the remote side. It is copied into the CPU data register only when the synchronized acknowledge arrives, and the busy bit clears in that same cycle. Only one transfer can be outstanding at any time.

Top module: `xdom_reg_bridge`

## Requirements
- R1: After reset, the control, mode, address and data registers all read zero, and no remote bus access is issued.
- R2: The CPU window decodes cpu_addr[3:2]: 0 = control, 1 = mode/byte-enable (8 bits), 2 = remote address (16 bits), 3 = data (32 bits). The staging registers read back what was written, truncated to their widths and zero-extended.
- R3: A CPU write of a value with bit 0 set to the control register while idle starts a transfer. From the next CPU cycle, the control register reads 1 until the transfer completes, and then reads 0.
- R4: When mode bit 0 is 0, the transfer is a read. On completion, the data register holds the value the remote register file returned.
- R5: When mode bit 0 is 1, the transfer is a write. The remote bus presents the staged address, the staged data, rbus_we = 1 and rbus_strb[i] = mode bit 4+i (byte i = data bits 8i+7:8i).
- R6: A transfer uses the address, mode and data values held at the moment of the start. Changes to the staging registers during the transfer do not affect it.
- R7: A start written while a transfer is busy is ignored. The busy status stays set and no extra remote access results.
- R8: Each transfer produces exactly one rbus_en pulse, one remote clock cycle long.
- R9: A control write with bit 0 clear starts nothing.
- R10: A write transfer leaves the CPU data register unchanged.
- R11: A write whose byte enables are partial changes only the enabled bytes of the remote register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU domain clock |
| cpu_rst_n | input | 1 | CPU domain active-low reset |
| cpu_sel | input | 1 | Register window select |
| cpu_wr | input | 1 | Write strobe (with cpu_sel) |
| cpu_addr | input | 4 | Byte offset into the window |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | CPU read data (combinational) |
| rmt_clk | input | 1 | Remote always-on domain clock |
| rmt_rst_n | input | 1 | Remote domain active-low reset |
| rbus_en | output | 1 | Single-cycle remote access strobe |
| rbus_we | output | 1 | Remote access is a write |
| rbus_strb | output | 4 | Remote byte strobes |
| rbus_addr | output | 16 | Remote register address |
| rbus_wdata | output | 32 | Remote write data |
| rbus_rdata | input | 32 | Remote read data, valid in the rbus_en cycle |

## Verification
The assertions take for granted that software follows the polling discipline. Staging registers may change during a transfer, but the data register is not written by the CPU in the very cycle a read completes. They also assume the remote register file answers a read combinationally in the strobe cycle. The directed stimulus issues CPU accesses only at falling CPU edges. It writes the data register during a transfer only in the write case, whose completion never loads that register. It models the remote file as a zero-wait array, with the two clocks at unrelated periods so that the synchronizer phases vary between transfers.

// File: rtl/xdom_brg_pkg.sv
package xdom_brg_pkg;
    parameter int BRG_DW = 32;
    parameter int BRG_AW = 16;
    localparam int BRG_NB   = BRG_DW / 8;
    localparam int MODE_W   = 4 + BRG_NB;
    localparam int STRB_LSB = 4;

    typedef enum logic [1:0] {
        OFF_CTRL = 2'd0,
        OFF_MODE = 2'd1,
        OFF_ADDR = 2'd2,
        OFF_DATA = 2'd3
    } win_off_e;

    typedef struct packed {
        logic              write;
        logic [BRG_NB-1:0] strb;
        logic [BRG_AW-1:0] addr;
        logic [BRG_DW-1:0] wdata;
    } xfer_t;
endpackage

// File: rtl/xdom_sync2.sv
module xdom_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[1];
endmodule

// File: rtl/xdom_cpu_win.sv
module xdom_cpu_win
    import xdom_brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [3:0]        addr,
    input  logic [BRG_DW-1:0] wdata,
    output logic [BRG_DW-1:0] rdata,
    input  logic              ack_sync,
    input  logic [BRG_DW-1:0] rmt_rdata,
    output logic              req_tog,
    output xfer_t             hold
);
    typedef struct packed {
        logic              busy;
        logic              req_tog;
        logic [MODE_W-1:0] mode;
        logic [BRG_AW-1:0] raddr;
        logic [BRG_DW-1:0] data;
        xfer_t             hold;
    } win_state_t;

    win_state_t s_d, s_q;
    win_off_e   off;
    logic       wr_hit, start_try, done;

    assign off       = win_off_e'(addr[3:2]);
    assign wr_hit    = sel && wr;
    assign start_try = wr_hit && (off == OFF_CTRL) && wdata[0];
    assign done      = s_q.busy && (ack_sync == s_q.req_tog);

    always_comb begin
        s_d = s_q;
        if (done) begin
            s_d.busy = 1'b0;
            if (!s_q.hold.write) s_d.data = rmt_rdata;
        end
        if (wr_hit) begin
            unique case (off)
                OFF_CTRL: begin
                    if (wdata[0] && !s_q.busy) begin
                        s_d.busy       = 1'b1;
                        s_d.req_tog    = ~s_q.req_tog;
                        s_d.hold.write = s_q.mode[0];
                        s_d.hold.strb  = s_q.mode[STRB_LSB +: BRG_NB];
                        s_d.hold.addr  = s_q.raddr;
                        s_d.hold.wdata = s_q.data;
                    end
                end
                OFF_MODE: s_d.mode  = wdata[MODE_W-1:0];
                OFF_ADDR: s_d.raddr = wdata[BRG_AW-1:0];
                OFF_DATA: s_d.data  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        rdata = '0;
        unique case (off)
            OFF_CTRL: rdata[0]          = s_q.busy;
            OFF_MODE: rdata[MODE_W-1:0] = s_q.mode;
            OFF_ADDR: rdata[BRG_AW-1:0] = s_q.raddr;
            OFF_DATA: rdata             = s_q.data;
            default:  rdata             = '0;
        endcase
    end

    assign req_tog = s_q.req_tog;
    assign hold    = s_q.hold;

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.busy) |-> $past(start_try));
    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |=> $stable(s_q.hold));
    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy && start_try && (ack_sync != s_q.req_tog)
        |=> s_q.busy && $stable(s_q.req_tog));
endmodule

// File: rtl/xdom_rmt_master.sv
module xdom_rmt_master
    import xdom_brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  xfer_t             hold,
    output logic              ack_tog,
    output logic [BRG_DW-1:0] rd_hold,
    output logic              bus_en,
    output logic              bus_we,
    output logic [BRG_NB-1:0] bus_strb,
    output logic [BRG_AW-1:0] bus_addr,
    output logic [BRG_DW-1:0] bus_wdata,
    input  logic [BRG_DW-1:0] bus_rdata
);
    typedef struct packed {
        logic              seen;
        logic [BRG_DW-1:0] rdata;
    } rmt_state_t;

    rmt_state_t s_d, s_q;
    logic       pend;

    assign pend = req_sync ^ s_q.seen;

    always_comb begin
        s_d = s_q;
        if (pend) begin
            s_d.seen = req_sync;
            if (!hold.write) s_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_en    = pend;
    assign bus_we    = pend && hold.write;
    assign bus_strb  = pend ? hold.strb : '0;
    assign bus_addr  = hold.addr;
    assign bus_wdata = hold.wdata;
    assign ack_tog   = s_q.seen;
    assign rd_hold   = s_q.rdata;

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |=> !bus_en);
    // R8
    ack_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(ack_tog));
endmodule

// File: rtl/xdom_reg_bridge.sv
module xdom_reg_bridge
    import xdom_brg_pkg::*;
(
    input  logic              cpu_clk,
    input  logic              cpu_rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [3:0]        cpu_addr,
    input  logic [BRG_DW-1:0] cpu_wdata,
    output logic [BRG_DW-1:0] cpu_rdata,
    input  logic              rmt_clk,
    input  logic              rmt_rst_n,
    output logic              rbus_en,
    output logic              rbus_we,
    output logic [BRG_NB-1:0] rbus_strb,
    output logic [BRG_AW-1:0] rbus_addr,
    output logic [BRG_DW-1:0] rbus_wdata,
    input  logic [BRG_DW-1:0] rbus_rdata
);
    logic              req_tog, req_sync, ack_tog, ack_sync;
    logic [BRG_DW-1:0] rd_hold;
    xfer_t             hold;

    xdom_cpu_win u_win (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .sel(cpu_sel), .wr(cpu_wr),
        .addr(cpu_addr), .wdata(cpu_wdata), .rdata(cpu_rdata),
        .ack_sync(ack_sync), .rmt_rdata(rd_hold),
        .req_tog(req_tog), .hold(hold)
    );

    xdom_sync2 u_req_sync (
        .clk(rmt_clk), .rst_n(rmt_rst_n), .din(req_tog), .dout(req_sync)
    );

    xdom_sync2 u_ack_sync (
        .clk(cpu_clk), .rst_n(cpu_rst_n), .din(ack_tog), .dout(ack_sync)
    );

    xdom_rmt_master u_rmt (
        .clk(rmt_clk), .rst_n(rmt_rst_n), .req_sync(req_sync), .hold(hold),
        .ack_tog(ack_tog), .rd_hold(rd_hold),
        .bus_en(rbus_en), .bus_we(rbus_we), .bus_strb(rbus_strb),
        .bus_addr(rbus_addr), .bus_wdata(rbus_wdata), .bus_rdata(rbus_rdata)
    );
endmodule

// File: tb/tb_xdom_reg_bridge.sv
`timescale 1ns/1ps
module tb_xdom_reg_bridge;
    logic        cpu_clk = 1'b0, rmt_clk = 1'b0;
    logic        cpu_rst_n = 1'b0, rmt_rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0, cpu_rdata;
    logic        rbus_en, rbus_we;
    logic [3:0]  rbus_strb;
    logic [15:0] rbus_addr;
    logic [31:0] rbus_wdata, rbus_rdata;

    logic [31:0] mem [16];
    int          pulse_cnt = 0;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    always #2 cpu_clk = ~cpu_clk;
    always #14.65 rmt_clk = ~rmt_clk;

    xdom_reg_bridge dut (
        .cpu_clk(cpu_clk), .cpu_rst_n(cpu_rst_n), .cpu_sel(cpu_sel),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .rmt_clk(rmt_clk), .rmt_rst_n(rmt_rst_n),
        .rbus_en(rbus_en), .rbus_we(rbus_we), .rbus_strb(rbus_strb),
        .rbus_addr(rbus_addr), .rbus_wdata(rbus_wdata), .rbus_rdata(rbus_rdata)
    );

    assign rbus_rdata = mem[rbus_addr[3:0]];

    always @(posedge rmt_clk) begin
        if (rbus_en) begin
            pulse_cnt <= pulse_cnt + 1;
            if (rbus_we)
                for (int b = 0; b < 4; b++)
                    if (rbus_strb[b]) mem[rbus_addr[3:0]][8*b +: 8] <= rbus_wdata[8*b +: 8];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge cpu_clk);
        cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge cpu_clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge cpu_clk);
        cpu_sel = 1'b1; cpu_wr = 1'b0; cpu_addr = a;
        #0.5 d = cpu_rdata;
        cpu_sel = 1'b0;
    endtask

    task automatic poll_idle(input string req);
        logic [31:0] v;
        v = 32'h1;
        for (int i = 0; i < 400 && v != 0; i++) cpu_read(4'h0, v);
        check(req, v, 32'h0);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int o = 0; o < 4; o++) begin
            cpu_read(4'(o * 4), v);
            check("R1", v, 32'h0);
        end
        check("R1 bus idle", 32'(pulse_cnt), 32'd0);
    endtask

    task automatic t_staging;
        logic [31:0] v;
        cpu_write(4'h8, 32'hABCD_1234);
        cpu_write(4'h4, 32'hFFFF_FF51);
        cpu_write(4'hC, 32'hDEAD_BEEF);
        cpu_read(4'h8, v); check("R2 addr", v, 32'h0000_1234);
        cpu_read(4'h4, v); check("R2 mode", v, 32'h0000_0051);
        cpu_read(4'hC, v); check("R2 data", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_write_full;
        logic [31:0] v;
        int p0;
        p0 = pulse_cnt;
        cpu_write(4'h8, 32'd3);
        cpu_write(4'h4, 32'hF1);
        cpu_write(4'hC, 32'hCAFE_F00D);
        cpu_write(4'h0, 32'h1);
        cpu_read(4'h0, v); check("R3 busy", v, 32'h1);
        poll_idle("R3 done");
        check("R5 write", mem[3], 32'hCAFE_F00D);
        check("R8 one pulse", 32'(pulse_cnt - p0), 32'd1);
        cpu_read(4'hC, v); check("R10 data kept", v, 32'hCAFE_F00D);
    endtask

    task automatic t_read;
        logic [31:0] v;
        mem[5] = 32'h5A5A_0F0F;
        cpu_write(4'h8, 32'd5);
        cpu_write(4'h4, 32'h0);
        cpu_write(4'hC, 32'h0);
        cpu_write(4'h0, 32'h1);
        poll_idle("R3 read done");
        cpu_read(4'hC, v); check("R4 read data", v, 32'h5A5A_0F0F);
    endtask

    task automatic t_partial;
        mem[7] = 32'h1122_3344;
        cpu_write(4'h8, 32'd7);
        cpu_write(4'h4, 32'h51);
        cpu_write(4'hC, 32'hAABB_CCDD);
        cpu_write(4'h0, 32'h1);
        poll_idle("R3 partial done");
        check("R11 partial", mem[7], 32'h11BB_33DD);
    endtask

    task automatic t_hold;
        mem[9] = 32'h0; mem[10] = 32'h0;
        cpu_write(4'h8, 32'd9);
        cpu_write(4'h4, 32'hF1);
        cpu_write(4'hC, 32'h0102_0304);
        cpu_write(4'h0, 32'h1);
        cpu_write(4'hC, 32'h9999_9999);
        cpu_write(4'h8, 32'd10);
        poll_idle("R6 done");
        check("R6 start-time data", mem[9], 32'h0102_0304);
        check("R6 start-time addr", mem[10], 32'h0);
    endtask

    task automatic t_busy_start;
        logic [31:0] v;
        int p0;
        mem[5] = 32'h7777_1111;
        cpu_write(4'h8, 32'd5);
        cpu_write(4'h4, 32'h0);
        p0 = pulse_cnt;
        cpu_write(4'h0, 32'h1);
        cpu_write(4'h0, 32'h1);
        cpu_read(4'h0, v); check("R7 busy kept", v, 32'h1);
        poll_idle("R7 done");
        repeat (200) @(negedge cpu_clk);
        check("R7 no extra access", 32'(pulse_cnt - p0), 32'd1);
        cpu_read(4'hC, v); check("R4 second read", v, 32'h7777_1111);
    endtask

    task automatic t_noop;
        logic [31:0] v;
        int p0;
        p0 = pulse_cnt;
        cpu_write(4'h0, 32'h2);
        cpu_read(4'h0, v); check("R9 not busy", v, 32'h0);
        repeat (200) @(negedge cpu_clk);
        check("R9 no access", 32'(pulse_cnt - p0), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (3) @(posedge rmt_clk);
        @(negedge cpu_clk);
        cpu_rst_n = 1'b1;
        rmt_rst_n = 1'b1;
        repeat (4) @(negedge cpu_clk);
        t_reset;
        t_staging;
        t_write_full;
        t_read;
        t_partial;
        t_hold;
        t_busy_start;
        t_noop;
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule